// File: doc/BRIEF.md
# Deadband Charge Accumulator

This block integrates signed current samples from a sense-resistor converter into two running totals, one for charge and one for discharge. Each sample has two offsets removed from it, an automatically calibrated internal offset and an offset programmed by the user to cover board-level error. The compensated value then passes a programmable magnitude deadband, so that the small residual that remains when no real current flows does not creep into either total.

Samples arrive on a valid/ready stream. The block never applies back-pressure: `in_ready` is low only during reset and high on every cycle after it, so a sample is taken on every clock edge where `in_valid` is high. The offsets and the threshold are sampled together with the sample they apply to. A freeze input stops accumulation: samples offered while it is high are consumed and discarded, and the totals do not move. Every sample that reaches the accumulation stage reports one result pulse telling whether it was counted, its direction and whether it was out of range.

Top module: `dbacc_top`

## Requirements
- R1: While `rst_n` is low both totals are zero, `res_valid` is low and `in_ready` is low; `in_ready` is high from the first clock edge after reset is released.
- R2: The compensated value is the sample minus `cal_offset` minus `user_offset`, all as two's complement; a positive compensated value that is counted adds its value to `chg_total`.
- R3: A negative compensated value that is counted adds its magnitude to `dis_total` and reports `res_discharge` high; counting never changes the total of the other direction.
- R4: A compensated value whose magnitude is below `db_thresh` (unsigned, one LSB per sample LSB) is not counted in either direction, and both totals stay unchanged.
- R5: A compensated value whose magnitude equals `db_thresh` is counted.
- R6: With `db_thresh` zero every non-zero compensated value in range is counted.
- R7: A compensated value of exactly zero is never counted and reports `res_counted` low.
- R8: A raw sample whose magnitude exceeds the full-scale code (default 20408) is not counted and reports `res_oor` high; a sample exactly at full scale is in range.
- R9: Each total saturates at its all-ones value instead of wrapping and then stays there.
- R10: On a clock edge where `freeze` is high, no sample is taken into the pipeline, a sample already inside the pipeline is dropped, no result is reported and both totals hold.
- R11: A sample taken at clock edge k updates the totals and raises `res_valid` for one cycle at edge k+1; the result flags are only high together with `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block accepts samples (high whenever out of reset) |
| in_sample | input | SAMPLE_W | Signed raw sample |
| cal_offset | input | OFFSET_W | Signed auto-calibrated internal offset |
| user_offset | input | OFFSET_W | Signed user-programmed external offset |
| db_thresh | input | THRESH_W | Unsigned deadband threshold, zero disables filtering |
| freeze | input | 1 | Hold totals and discard samples |
| chg_total | output | ACC_W | Saturating charge total |
| dis_total | output | ACC_W | Saturating discharge total |
| res_valid | output | 1 | One-cycle pulse: a sample finished accumulation |
| res_counted | output | 1 | The finished sample was accumulated |
| res_discharge | output | 1 | The finished sample's compensated value was negative |
| res_oor | output | 1 | The finished sample was out of range |

## Verification
A sample handed over at edge k moves the totals and the result flags at edge k+1, two edges after the inputs were driven, while `in_ready` follows reset release by one edge. The bench drives inputs on falling edges, advances a queue-based reference model on each rising edge under the same acceptance and freeze rules, and compares every output on the following falling edge, so each result is sampled in the half-cycle right after the edge that produced it. Directed checks add fixed expected totals after the deadband, threshold-equality, zero, range, freeze and saturation sequences, and one check confirms that `res_valid` is still low one edge after acceptance and high the edge after.

// File: rtl/dbacc_pkg.sv
package dbacc_pkg;

  typedef enum logic {
    DIR_CHG = 1'b0,
    DIR_DIS = 1'b1
  } dir_e;

  localparam int NUM_DIR = 2;

endpackage

// File: rtl/dbacc_offset_comp.sv
module dbacc_offset_comp #(
  parameter int SAMPLE_W = 16,
  parameter int OFFSET_W = 8,
  localparam int COMP_W  = SAMPLE_W + 2
) (
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic signed [OFFSET_W-1:0] off_a,
  input  logic signed [OFFSET_W-1:0] off_b,
  output logic signed [COMP_W-1:0]   comp
);

  logic signed [COMP_W-1:0] sample_x;
  logic signed [COMP_W-1:0] off_a_x;
  logic signed [COMP_W-1:0] off_b_x;

  always_comb begin
    sample_x = COMP_W'(sample);
    off_a_x  = COMP_W'(off_a);
    off_b_x  = COMP_W'(off_b);
    comp     = sample_x - off_a_x - off_b_x;
  end

endmodule

// File: rtl/dbacc_range_chk.sv
module dbacc_range_chk #(
  parameter int SAMPLE_W   = 16,
  parameter int FULL_SCALE = 20408
) (
  input  logic signed [SAMPLE_W-1:0] sample,
  output logic                       oor
);

  localparam int EXT_W = SAMPLE_W + 1;

  logic signed [EXT_W-1:0] ext;
  logic [EXT_W-1:0]        rmag;

  always_comb begin
    ext  = EXT_W'(sample);
    rmag = ext[EXT_W-1] ? $unsigned(-ext) : $unsigned(ext);
    oor  = rmag > EXT_W'(FULL_SCALE);
  end

endmodule

// File: rtl/dbacc_classify.sv
module dbacc_classify
  import dbacc_pkg::*;
#(
  parameter int COMP_W   = 18,
  parameter int THRESH_W = 8
) (
  input  logic signed [COMP_W-1:0] comp,
  input  logic                     oor,
  input  logic [THRESH_W-1:0]      thresh,
  output logic [COMP_W-1:0]        mag,
  output dir_e                     dir,
  output logic                     counted
);

  logic negative;
  logic nonzero;
  logic pass_band;

  always_comb begin
    negative  = comp[COMP_W-1];
    nonzero   = |comp;
    mag       = negative ? $unsigned(-comp) : $unsigned(comp);
    dir       = negative ? DIR_DIS : DIR_CHG;
    // threshold zero lets every non-zero magnitude through
    pass_band = mag >= COMP_W'(thresh);
    counted   = !oor && nonzero && pass_band;
  end

endmodule

// File: rtl/dbacc_sat_acc.sv
module dbacc_sat_acc #(
  parameter int ACC_W = 24,
  parameter int MAG_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [MAG_W-1:0] add,
  output logic [ACC_W-1:0] q
);

  localparam int SUM_W = ((ACC_W > MAG_W) ? ACC_W : MAG_W) + 1;
  localparam logic [SUM_W-1:0] CEIL = SUM_W'({ACC_W{1'b1}});

  logic [SUM_W-1:0] sum;
  logic [ACC_W-1:0] next;

  always_comb begin
    sum  = SUM_W'(q) + SUM_W'(add);
    next = (sum > CEIL) ? {ACC_W{1'b1}} : sum[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en) begin
      q <= next;
    end
  end

endmodule

// File: rtl/dbacc_top.sv
module dbacc_top
  import dbacc_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int OFFSET_W   = 8,
  parameter int THRESH_W   = 8,
  parameter int ACC_W      = 24,
  parameter int FULL_SCALE = 20408
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic signed [SAMPLE_W-1:0] in_sample,
  input  logic signed [OFFSET_W-1:0] cal_offset,
  input  logic signed [OFFSET_W-1:0] user_offset,
  input  logic [THRESH_W-1:0]        db_thresh,
  input  logic                       freeze,
  output logic [ACC_W-1:0]           chg_total,
  output logic [ACC_W-1:0]           dis_total,
  output logic                       res_valid,
  output logic                       res_counted,
  output logic                       res_discharge,
  output logic                       res_oor
);

  localparam int COMP_W = SAMPLE_W + 2;

  // ---------------- stage A: compensation and range ----------------
  logic signed [COMP_W-1:0] comp_a;
  logic                     oor_a;
  logic                     take;

  dbacc_offset_comp #(
    .SAMPLE_W (SAMPLE_W),
    .OFFSET_W (OFFSET_W)
  ) u_comp (
    .sample (in_sample),
    .off_a  (cal_offset),
    .off_b  (user_offset),
    .comp   (comp_a)
  );

  dbacc_range_chk #(
    .SAMPLE_W   (SAMPLE_W),
    .FULL_SCALE (FULL_SCALE)
  ) u_range (
    .sample (in_sample),
    .oor    (oor_a)
  );

  assign take = in_valid && in_ready;

  logic                     ready_q;
  logic                     s1_valid;
  logic signed [COMP_W-1:0] s1_comp;
  logic                     s1_oor;
  logic [THRESH_W-1:0]      s1_thresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q   <= 1'b0;
      s1_valid  <= 1'b0;
      s1_comp   <= '0;
      s1_oor    <= 1'b0;
      s1_thresh <= '0;
    end else begin
      ready_q  <= 1'b1;
      s1_valid <= take && !freeze;
      if (take) begin
        s1_comp   <= comp_a;
        s1_oor    <= oor_a;
        s1_thresh <= db_thresh;
      end
    end
  end

  assign in_ready = ready_q;

  // ---------------- stage B: deadband and accumulation ----------------
  logic [COMP_W-1:0] mag_b;
  dir_e              dir_b;
  logic              count_b;
  logic              step;

  dbacc_classify #(
    .COMP_W   (COMP_W),
    .THRESH_W (THRESH_W)
  ) u_class (
    .comp    (s1_comp),
    .oor     (s1_oor),
    .thresh  (s1_thresh),
    .mag     (mag_b),
    .dir     (dir_b),
    .counted (count_b)
  );

  assign step = s1_valid && !freeze;

  logic [NUM_DIR-1:0]            acc_en;
  logic [NUM_DIR-1:0][ACC_W-1:0] totals;

  for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
    assign acc_en[g] = step && count_b && (dir_b == dir_e'(g));

    dbacc_sat_acc #(
      .ACC_W (ACC_W),
      .MAG_W (COMP_W)
    ) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (acc_en[g]),
      .add   (mag_b),
      .q     (totals[g])
    );
  end

  assign chg_total = totals[DIR_CHG];
  assign dis_total = totals[DIR_DIS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid     <= 1'b0;
      res_counted   <= 1'b0;
      res_discharge <= 1'b0;
      res_oor       <= 1'b0;
    end else begin
      res_valid     <= step;
      res_counted   <= step && count_b;
      res_discharge <= step && (dir_b == DIR_DIS);
      res_oor       <= step && s1_oor;
    end
  end

endmodule

// File: rtl/dbacc_checker.sv
module dbacc_checker #(
  parameter int ACC_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             freeze,
  input logic             in_ready,
  input logic [ACC_W-1:0] chg_total,
  input logic [ACC_W-1:0] dis_total,
  input logic             res_valid,
  input logic             res_counted,
  input logic             res_discharge,
  input logic             res_oor
);

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (chg_total == '0 && dis_total == '0 && !res_valid && !in_ready));

  assert_chg_monotonic_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> chg_total >= $past(chg_total));

  assert_dis_monotonic_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> dis_total >= $past(dis_total));

  assert_charge_side_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_counted && !res_discharge) |-> dis_total == $past(dis_total));

  assert_uncounted_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_counted) |->
      (chg_total == $past(chg_total) && dis_total == $past(dis_total)));

  assert_oor_not_counted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_oor |-> !res_counted);

  assert_chg_sat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_total == '1) |=> (chg_total == '1));

  assert_dis_sat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_total == '1) |=> (dis_total == '1));

  assert_freeze_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> ($stable(chg_total) && $stable(dis_total) && !res_valid));

  assert_flags_need_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_counted || res_discharge || res_oor) |-> res_valid);

endmodule

bind dbacc_top dbacc_checker #(
  .ACC_W (ACC_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .freeze        (freeze),
  .in_ready      (in_ready),
  .chg_total     (chg_total),
  .dis_total     (dis_total),
  .res_valid     (res_valid),
  .res_counted   (res_counted),
  .res_discharge (res_discharge),
  .res_oor       (res_oor)
);

// File: tb/dbacc_top_tb.sv
module dbacc_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SW      = 16;
  localparam int OW      = 8;
  localparam int TW      = 8;
  localparam int AW      = 16;
  localparam int FS      = 20408;
  localparam int ACC_MAX = (1 << AW) - 1;
  localparam int WD_LIMIT = 20000;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic signed [SW-1:0] in_sample = '0;
  logic signed [OW-1:0] cal_offset = '0;
  logic signed [OW-1:0] user_offset = '0;
  logic [TW-1:0]        db_thresh = '0;
  logic                 freeze = 1'b0;
  logic [AW-1:0]        chg_total;
  logic [AW-1:0]        dis_total;
  logic                 res_valid;
  logic                 res_counted;
  logic                 res_discharge;
  logic                 res_oor;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbacc_top #(
    .SAMPLE_W   (SW),
    .OFFSET_W   (OW),
    .THRESH_W   (TW),
    .ACC_W      (AW),
    .FULL_SCALE (FS)
  ) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_sample     (in_sample),
    .cal_offset    (cal_offset),
    .user_offset   (user_offset),
    .db_thresh     (db_thresh),
    .freeze        (freeze),
    .chg_total     (chg_total),
    .dis_total     (dis_total),
    .res_valid     (res_valid),
    .res_counted   (res_counted),
    .res_discharge (res_discharge),
    .res_oor       (res_oor)
  );

  // ---------------- reference model ----------------
  typedef struct {
    int comp;
    bit oor;
    int thr;
  } rec_t;

  rec_t pipe[$];
  int   m_chg = 0;
  int   m_dis = 0;
  bit   m_ready = 0;
  bit   m_rv = 0;
  bit   m_cnt = 0;
  bit   m_neg = 0;
  bit   m_oor = 0;
  bit   m_take;
  rec_t r_new;
  rec_t r_cur;
  int   m_mag;
  int   raw;

  always @(posedge clk) begin
    if (!rst_n) begin
      pipe.delete();
      m_chg = 0; m_dis = 0; m_ready = 0;
      m_rv = 0; m_cnt = 0; m_neg = 0; m_oor = 0;
    end else begin
      m_take = m_ready && in_valid;
      m_rv = 0; m_cnt = 0; m_neg = 0; m_oor = 0;
      if (freeze) begin
        pipe.delete();
      end else if (pipe.size() > 0) begin
        r_cur = pipe.pop_front();
        m_mag = (r_cur.comp < 0) ? -r_cur.comp : r_cur.comp;
        m_rv  = 1;
        m_neg = r_cur.comp < 0;
        m_oor = r_cur.oor;
        m_cnt = !r_cur.oor && r_cur.comp != 0 && m_mag >= r_cur.thr;
        if (m_cnt) begin
          if (r_cur.comp > 0) m_chg = (m_chg + m_mag > ACC_MAX) ? ACC_MAX : m_chg + m_mag;
          else                m_dis = (m_dis + m_mag > ACC_MAX) ? ACC_MAX : m_dis + m_mag;
        end
      end
      if (m_take && !freeze) begin
        raw        = int'(in_sample);
        r_new.comp = raw - int'(cal_offset) - int'(user_offset);
        r_new.oor  = ((raw < 0) ? -raw : raw) > FS;
        r_new.thr  = int'(db_thresh);
        pipe.push_back(r_new);
      end
      m_ready = 1;
    end
  end

  // ---------------- checking ----------------
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 0;
  string phase = "R1";

  task automatic cmp(string tag, string sig, int act, int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, sig, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      cmp(phase, "in_ready",      int'(in_ready),      int'(m_ready));
      cmp(phase, "chg_total",     int'(chg_total),     m_chg);
      cmp(phase, "dis_total",     int'(dis_total),     m_dis);
      cmp(phase, "res_valid",     int'(res_valid),     int'(m_rv));
      cmp(phase, "res_counted",   int'(res_counted),   int'(m_cnt));
      cmp(phase, "res_discharge", int'(res_discharge), int'(m_neg));
      cmp(phase, "res_oor",       int'(res_oor),       int'(m_oor));
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, WD_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(int s);
    in_valid  = 1'b1;
    in_sample = SW'(s);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    cmp("R1", "chg_total reset", int'(chg_total), 0);
    cmp("R1", "in_ready reset", int'(in_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1", "in_ready after release", int'(in_ready), 1);

    // R2: offsets subtracted, positive to charge
    phase = "R2";
    db_thresh = 0; cal_offset = 3; user_offset = -2;
    drive(100);
    idle(3);
    cmp("R2", "chg after 100-3+2", int'(chg_total), 99);

    // R3: negative to discharge
    phase = "R3";
    drive(-50);
    idle(3);
    cmp("R3", "dis after -50-1", int'(dis_total), 51);
    cmp("R3", "chg untouched", int'(chg_total), 99);

    // R4: below threshold ignored both ways
    phase = "R4";
    db_thresh = 10;
    drive(10); drive(-8);
    idle(3);
    cmp("R4", "chg below band", int'(chg_total), 99);
    cmp("R4", "dis below band", int'(dis_total), 51);

    // R5: equal to threshold counted
    phase = "R5";
    drive(11); drive(-9);
    idle(3);
    cmp("R5", "chg at band", int'(chg_total), 109);
    cmp("R5", "dis at band", int'(dis_total), 61);

    // R6: threshold zero counts magnitude one
    phase = "R6";
    db_thresh = 0;
    drive(2); drive(0);
    idle(3);
    cmp("R6", "chg +1", int'(chg_total), 110);
    cmp("R6", "dis +1", int'(dis_total), 62);

    // R11 and R7: latency and zero never counted
    phase = "R11";
    in_valid = 1'b1; in_sample = 16'sd1;
    @(negedge clk);
    in_valid = 1'b0;
    cmp("R11", "res_valid one edge after take", int'(res_valid), 0);
    @(negedge clk);
    cmp("R11", "res_valid two edges after take", int'(res_valid), 1);
    cmp("R7", "zero compensated counted", int'(res_counted), 0);
    idle(2);
    phase = "R7";
    cmp("R7", "chg after zero", int'(chg_total), 110);

    // R8: range limits
    phase = "R8";
    cal_offset = 0; user_offset = 0;
    drive(FS + 1); drive(-(FS + 1)); drive(-32768); drive(FS);
    idle(3);
    cmp("R8", "chg after range set", int'(chg_total), 110 + FS);
    cmp("R8", "dis after range set", int'(dis_total), 62);

    // R10: freeze drops offered and in-flight samples
    phase = "R10";
    freeze = 1'b1;
    drive(500); drive(-500); drive(500);
    freeze = 1'b0;
    idle(2);
    drive(500);
    freeze = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    freeze = 1'b0;
    idle(3);
    cmp("R10", "chg held by freeze", int'(chg_total), 110 + FS);
    cmp("R10", "dis held by freeze", int'(dis_total), 62);
    drive(500);
    idle(3);
    cmp("R10", "chg after unfreeze", int'(chg_total), 610 + FS);

    // mixed patterns under the model
    phase = "R4";
    for (int i = 0; i < 300; i++) begin
      cal_offset  = OW'(int'($urandom_range(15)) - 8);
      user_offset = OW'(int'($urandom_range(15)) - 8);
      db_thresh   = TW'($urandom_range(31));
      freeze      = ($urandom_range(7) == 0);
      if ($urandom_range(19) == 0) drive(($urandom_range(1) == 0) ? 25000 : -25000);
      else if ($urandom_range(3) == 0) idle(1);
      else drive(int'($urandom_range(1200)) - 600);
    end
    freeze = 1'b0;
    idle(3);

    // R9: saturation
    phase = "R9";
    db_thresh = 0; cal_offset = 0; user_offset = 0;
    drive(20000); drive(20000); drive(20000); drive(20000);
    drive(-20000); drive(-20000); drive(-20000); drive(-20000);
    idle(3);
    cmp("R9", "chg saturated", int'(chg_total), ACC_MAX);
    cmp("R9", "dis saturated", int'(dis_total), ACC_MAX);
    drive(7); drive(-7);
    idle(3);
    cmp("R9", "chg stays saturated", int'(chg_total), ACC_MAX);
    cmp("R9", "dis stays saturated", int'(dis_total), ACC_MAX);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule